// File: doc/BRIEF.md
# Iterative Signed-Digit Multiplier

This block multiplies two signed two's-complement words of width `N` over several clock cycles and delivers the full `2N`-bit product. It does not store a signed-digit copy of the multiplier. Each cycle it reads a four-bit window at the bottom of a shifting copy of the multiplier. That window becomes a single signed digit of value 0, ±1 or ±2 and an advance of two or three bit positions. A digit of value 0 leaves the accumulator untouched. A value of ±1 or ±2 adds or subtracts the multiplicand, or twice the multiplicand, at the current weight.

The operation ends when the unscanned part of the multiplier is a run of identical sign bits. The number of cycles therefore depends on the multiplier value and not on the operand width. A client holds `start` high for one cycle while the block is idle and then waits for the one-cycle `done` pulse. The product stays on its port until the next accepted start.

Top module: `csd_iter_mul`

## Requirements
- R1: After reset `busy` and `done` are low and `product` is zero.
- R2: When `done` is high, `product` equals the exact signed product `mcand * mplier`, taken as a `2N`-bit two's-complement value, for every operand pair.
- R3: A `start` seen while idle is accepted, and `busy` is high in the following cycle. A `start` seen while `busy` is high is ignored: the running operation keeps its operands, its result and its cycle count.
- R4: `done` is high for exactly one cycle, in the first cycle in which `busy` is low after an operation.
- R5: A zero multiplier needs no iteration: `busy` is high for exactly one cycle and `product` is zero.
- R6: A window whose four bits are all 0 skips the accumulator and advances three positions. A multiplier of 8 therefore finishes in two iterations (`busy` high for 3 cycles), and a multiplier of 1 finishes in one iteration (2 cycles).
- R7: For a window (b[i+2], b[i+1], b[i], b[i-1]), with b[-1] = 0 at the start, the wide digit is -4·b[i+2] + 2·b[i+1] + b[i] + b[i-1]. When that digit lies in [-2, 2] it is applied and the scan advances three positions. Otherwise the narrow digit -2·b[i+1] + b[i] + b[i-1] is applied and the scan advances two positions. Only ±a and ±2a are ever used. A multiplier of 0x55 therefore takes four iterations (5 busy cycles).
- R8: Iteration stops once all unscanned multiplier bits, including b[i-1], are equal. No operation takes more than ceil(N/2) iterations, so `busy` is high for at most ceil(N/2)+1 cycles.
- R9: While the block is idle and no start arrives, `product` does not change.
- R10: A multiplier of -1 takes one iteration (`busy` high for 2 cycles) and yields the negated multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| mcand | input | N | Multiplicand, signed |
| mplier | input | N | Multiplier, signed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Signed product, valid from `done` onward |

## Verification
The end of the last iteration and a new `start` can arrive in the same cycle. The block is still busy in that cycle, so the request must be dropped. The bench runs a multiplier of 8, which takes three busy cycles, and raises `start` with different operands in exactly the third of them. It then requires the first pair's product at `done`, `busy` low in the next cycle, and an unchanged product afterwards. A second run raises `start` in the middle of a four-iteration operation and requires that the result and the cycle count stay the same.

// File: rtl/csd_iter_mul_pkg.sv
package csd_iter_mul_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // perform one recoded iteration
  } dpCtl_t;

  // One recoded signed digit plus its advance
  typedef struct packed {
    logic sub;     // subtract the selected multiple
    logic short2;  // advance by two positions instead of three
    logic skip;    // digit is zero: accumulator untouched
    logic dbl;     // use twice the multiplicand
  } digit_t;

endpackage

// File: rtl/csd_win_recoder.sv
module csd_win_recoder
  import csd_iter_mul_pkg::*;
(
  input  logic [3:0] win,   // {b[i+2], b[i+1], b[i], b[i-1]}
  output digit_t     dig
);

  logic signed [3:0] wide;
  logic signed [3:0] narrow;
  logic signed [3:0] pick;
  logic              useWide;

  // wide digit covers three positions, narrow digit covers two
  assign wide = $signed({3'b000, win[1]}) + $signed({3'b000, win[0]})
              + $signed({2'b00, win[2], 1'b0}) - (win[3] ? 4'sd4 : 4'sd0);
  assign narrow = $signed({3'b000, win[1]}) + $signed({3'b000, win[0]})
                - (win[2] ? 4'sd2 : 4'sd0);

  assign useWide = (wide >= -4'sd2) && (wide <= 4'sd2);
  assign pick    = useWide ? wide : narrow;

  always_comb begin
    dig.sub    = pick[3];
    dig.short2 = !useWide;
    dig.skip   = (pick == 4'sd0);
    dig.dbl    = (pick == 4'sd2) || (pick == -4'sd2);
  end

endmodule

// File: rtl/csd_iter_mul_dp.sv
module csd_iter_mul_dp
  import csd_iter_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtl_t         ctl,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           flat,
  output logic [2*N-1:0] product
);

  localparam int PW = 2 * N;          // accumulator width
  localparam int MW = N + 1;          // multiplier copy plus the b[-1] slot
  localparam int CW = $clog2(PW + 4); // weight counter width

  logic [N-1:0]  aReg;
  logic [MW-1:0] mq;
  logic [PW-1:0] acc;
  logic [CW-1:0] pos;
  digit_t        dig;
  logic [PW-1:0] aExt;
  logic [PW-1:0] mult;
  logic [PW-1:0] addend;

  csd_win_recoder u_rec (
    .win (mq[3:0]),
    .dig (dig)
  );

  assign aExt   = {{N{aReg[N-1]}}, aReg};
  assign mult   = dig.dbl ? (aExt << (pos + CW'(1))) : (aExt << pos);
  assign addend = dig.sub ? (~mult + PW'(1)) : mult;

  // remaining bits all equal: nothing more to contribute
  assign flat    = (mq == '0) || (&mq);
  assign product = acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      mq   <= '0;
      acc  <= '0;
      pos  <= '0;
    end else if (ctl.load) begin
      aReg <= mcand;
      mq   <= {mplier, 1'b0};
      acc  <= '0;
      pos  <= '0;
    end else if (ctl.step) begin
      mq  <= $signed(mq) >>> (dig.short2 ? 2 : 3);
      pos <= pos + (dig.short2 ? CW'(2) : CW'(3));
      if (!dig.skip) acc <= acc + addend;
    end
  end

endmodule

// File: rtl/csd_iter_mul_ctl.sv
module csd_iter_mul_ctl
  import csd_iter_mul_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   flat,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);

  always_comb begin
    ctl.load = !busy && start;
    ctl.step = busy && !flat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
      end else if (busy && flat) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/csd_iter_mul.sv
module csd_iter_mul
  import csd_iter_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  dpCtl_t ctl;
  logic   flat;

  csd_iter_mul_ctl u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .flat  (flat),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  csd_iter_mul_dp #(.N(N)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .mcand   (mcand),
    .mplier  (mplier),
    .flat    (flat),
    .product (product)
  );

endmodule

// File: rtl/csd_iter_mul_chk.sv
module csd_iter_mul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);

  localparam int MAXI = (N + 1) / 2;   // iteration ceiling
  localparam int KW   = $clog2(N + 8);

  logic [KW-1:0] iterCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      iterCnt <= '0;
    else if (busy)  iterCnt <= iterCnt + KW'(1);
    else            iterCnt <= '0;
  end

  p_accept_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  p_busy_needs_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_product_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

  p_iter_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(iterCnt) <= MAXI));

endmodule

bind csd_iter_mul csd_iter_mul_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/csd_iter_mul_bench.sv
module csd_iter_mul_bench;

  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  csd_iter_mul #(.N(N)) u_csd_iter_mul (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] refMul(input logic [N-1:0] a, input logic [N-1:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[2*N-1:0];
  endfunction

  // Runs one operation; inj >= 1 raises start with other operands
  // during that busy cycle. Returns busy cycle count and product.
  task automatic runOp(input logic [N-1:0] a, input logic [N-1:0] b, input int inj,
                       output int cyc, output logic [2*N-1:0] prod, output logic busyNext);
    int guard;
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyNext = busy;
    cyc = 0; guard = 0;
    while (!done && guard < 100) begin
      if (busy) cyc++;
      if (cyc == inj && busy) begin
        start = 1'b1; mcand = ~a; mplier = b ^ 8'h5A;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    if (guard >= 100) begin
      errors++;
      $display("FAIL R4: no done, actual timeout expected done");
    end
    prod = product;
  endtask

  task automatic testReset();
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 product", 32'(product), 32'd0);
  endtask

  task automatic testZeroMultiplier();
    int c; logic [2*N-1:0] p; logic bn;
    runOp(8'd77, 8'd0, -1, c, p, bn);
    check("R5 cycles", 32'(c), 32'd1);
    check("R5 product", 32'(p), 32'd0);
    check("R3 busy after start", 32'(bn), 32'd1);
  endtask

  task automatic testWindowCounts();
    int c; logic [2*N-1:0] p; logic bn;
    runOp(8'd19, 8'd8, -1, c, p, bn);
    check("R6 mult 8 cycles", 32'(c), 32'd3);
    check("R6 mult 8 product", 32'(p), 32'(refMul(8'd19, 8'd8)));
    runOp(8'd19, 8'd1, -1, c, p, bn);
    check("R6 mult 1 cycles", 32'(c), 32'd2);
    check("R6 mult 1 product", 32'(p), 32'(refMul(8'd19, 8'd1)));
    runOp(8'd105, 8'h55, -1, c, p, bn);
    check("R7 mult 0x55 cycles", 32'(c), 32'd5);
    check("R7 mult 0x55 product", 32'(p), 32'(refMul(8'd105, 8'h55)));
    runOp(8'hC3, 8'hFF, -1, c, p, bn);
    check("R10 mult -1 cycles", 32'(c), 32'd2);
    check("R10 mult -1 product", 32'(p), 32'(refMul(8'hC3, 8'hFF)));
  endtask

  task automatic testSweep();
    logic [N-1:0] aSet [12] = '{8'h80, 8'h81, 8'hFF, 8'h00, 8'h01, 8'h02,
                                8'h7F, 8'h55, 8'hAA, 8'h33, 8'hC9, 8'h6E};
    int maxCyc = 0;
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 12; k++) begin
        int c; logic [2*N-1:0] p; logic bn;
        logic [N-1:0] a;
        a = aSet[k] ^ 8'(b * 3 * (k & 1));
        runOp(a, 8'(b), -1, c, p, bn);
        check("R2 product", 32'(p), 32'(refMul(a, 8'(b))));
        if (c > maxCyc) maxCyc = c;
        checks++;
        if (c > (N + 1) / 2 + 1) begin
          errors++;
          $display("FAIL R8 cycle bound: actual %0d expected <= %0d", c, (N + 1) / 2 + 1);
        end
      end
    end
    $display("sweep: longest operation %0d busy cycles", maxCyc);
  endtask

  task automatic testStartIgnored();
    int c; logic [2*N-1:0] p; logic bn;
    runOp(8'd5, 8'h55, 2, c, p, bn);
    check("R3 mid-run start cycles", 32'(c), 32'd5);
    check("R3 mid-run start product", 32'(p), 32'(refMul(8'd5, 8'h55)));
  endtask

  task automatic testFinalCycleCollision();
    int c; logic [2*N-1:0] p; logic bn;
    runOp(8'hE7, 8'd8, 3, c, p, bn);
    check("R3 final-cycle start product", 32'(p), 32'(refMul(8'hE7, 8'd8)));
    check("R4 final-cycle done count", 32'(c), 32'd3);
    @(negedge clk);
    check("R3 final-cycle start not taken", 32'(busy), 32'd0);
    check("R4 done one cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    check("R9 product held", 32'(product), 32'(refMul(8'hE7, 8'd8)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroMultiplier();
    testWindowCounts();
    testStartIgnored();
    testFinalCycleCollision();
    testSweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule